// File: doc/BRIEF.md
# PCI Interrupt Line Mapper and Gate

This block sits in a PCI host bridge between the devices that raise level-sensitive interrupts and the interrupt controller. It takes interrupt level changes from devices, each tagged with the device/function number of the source, the interrupt pin index it uses, and whether the device sits directly on the primary bus or behind a secondary bridge. From these it works out a line number in the range 0 to 31 and remembers the current level of every line. Each of the 32 outputs toward the interrupt controller carries that level, but only while the mapping register that owns the line has its enable bit set. Otherwise the output is held low.

Eight 32-bit mapping registers sit in a 64-byte window of the bridge's register space. Software can change only the top bit of each register, which is the enable bit. The lower 31 bits hold a fixed routing code that is set at reset. A separate bridge reset input clears all eight enable bits and leaves the routing codes as they are. Interrupt updates arrive on a valid/ready stream. `src_ready` is always high, so an update is taken in every cycle in which `src_valid` is high, and the source never sees back-pressure. Interrupt priority and vectoring are left to the controller downstream.

Top module: `irqmap_top`

## Requirements
- R1: After the synchronous reset `rst`, register i (0..7) reads as `{1'b0, 0x7C0 | (i << 2)}` (for example, register 0 reads 0x000007C0 and register 7 reads 0x000007DC), and all 32 outputs are low.
- R2: A write to a mapping register loads bit 31 from `cfg_wdata[31]`. Bits 30:0 keep their routing code whatever the written data is.
- R3: The mapping registers occupy offsets 0xC00 to 0xC3F. The register index is offset bits 5:3, and only offsets with bit 2 set reach a register. A read of any other offset, whether it has bit 2 clear or lies outside the window, returns zero. A write to any such offset changes no register.
- R4: A cycle with `bridge_rst` high clears bit 31 of all eight registers and leaves bits 30:0 unchanged.
- R5: Line n is owned by register n >> 2. While that register is enabled, output n carries the last level received for line n. While it is disabled, output n is low. The level received is remembered even while the line is disabled.
- R6: For a source on the primary bus (`src_sec` = 0), the line is `src_pin + 16` when `src_devfn[0]` is 1, and `src_pin` when it is 0.
- R7: For a source behind a secondary bridge (`src_sec` = 1), the line is `((src_devfn & 0x18) >> 1) + src_pin`.
- R8: An update whose computed line is 32 or more is dropped, and every output keeps its value.
- R9: `src_ready` is always high. An update taken at clock edge k, or an enable change made at edge k, shows on `irq_out` after edge k+1.
- R10: When `bridge_rst` and a register write fall in the same cycle, the bridge reset wins and the enable ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of all state |
| bridge_rst | input | 1 | Clears every enable bit; routing codes are kept |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 16 | Register offset for reads and writes |
| cfg_wdata | input | 32 | Write data; only bit 31 is used |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| src_valid | input | 1 | Interrupt level update is present |
| src_ready | output | 1 | Always high; an update is taken whenever valid |
| src_sec | input | 1 | 1: source is behind a secondary bridge; 0: primary bus |
| src_devfn | input | 8 | Device/function number of the source |
| src_pin | input | 5 | Interrupt pin index of the source |
| src_level | input | 1 | New level of the source interrupt |
| irq_out | output | 32 | Gated interrupt levels toward the controller |

## Verification
The bench sends updates with `src_devfn` bit 0 both set and clear on each bus type, including secondary sources with bit 0 set, which that path must ignore. A design that mixed up the two formulas would raise the wrong output bit. The sums 36 and 37 exercise the drop rule; a design that truncated them to five bits would raise lines 4 and 5. Writes with data that has all low bits set, offsets with bit 2 clear, and offsets that would alias outside the window all check that only the enable bit moves. A design that stored the full word, or decoded only the low six address bits, would read back changed routing codes or enable the wrong register. A design that did not remember levels while a line was gated would get the re-enable step wrong, and one that let a same-cycle write override the bridge reset would show an enabled register afterwards.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

  // Fixed routing code base placed in bits 30:0 of every mapping register.
  localparam logic [30:0] ROUTE_BASE = 31'h7C0;

  // Routing code of mapping register idx after reset.
  function automatic logic [30:0] route_code(input int unsigned idx);
    logic [30:0] code;
    code = ROUTE_BASE | 31'(idx << 2);
    return code;
  endfunction

endpackage

// File: rtl/irqmap_regs.sv
module irqmap_regs
  import irqmap_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WIN_BASE = 'hC00
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bridge_rst,
  input  logic                cfg_wr,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic [NUM_REGS-1:0] en_o
);

  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  localparam int unsigned OFF_W = IDX_W + 3;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WIN_BASE);

  logic [NUM_REGS-1:0] en_q;
  logic                win_hit;
  logic                reg_sel;
  logic                wr_hit;
  logic [IDX_W-1:0]    idx;

  assign win_hit = (cfg_addr[ADDR_W-1:OFF_W] == BASE_V[ADDR_W-1:OFF_W]);
  assign reg_sel = win_hit & cfg_addr[2];
  assign idx     = cfg_addr[OFF_W-1:3];
  assign wr_hit  = cfg_wr & reg_sel;

  // Only the enable bit is stored; the routing code is a constant per index.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (bridge_rst) begin
      en_q <= '0;                       // R10: bridge reset beats a write
    end else if (wr_hit) begin
      en_q[idx] <= cfg_wdata[31];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (reg_sel) begin
      cfg_rdata = {en_q[idx], route_code(int'(idx))};
    end
  end

  assign en_o = en_q;

  a_r4_bridge_clears: assert property (@(posedge clk) disable iff (rst)
    bridge_rst |=> (en_q == '0));

  a_r2_enable_held: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && !bridge_rst) |=> $stable(en_q));

  a_r3_gap_reads_zero: assert property (@(posedge clk) disable iff (rst)
    !cfg_addr[2] |-> (cfg_rdata == '0));

endmodule

// File: rtl/irqmap_line_calc.sv
module irqmap_line_calc #(
  parameter int unsigned DEVFN_W   = 8,
  parameter int unsigned PIN_W     = 5,
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned LINE_W    = 6
) (
  input  logic               sec,
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [PIN_W-1:0]   pin,
  output logic [LINE_W-1:0]  line,
  output logic               in_range
);

  // Primary-bus sources with devfn bit 0 set land in the upper half.
  localparam int unsigned PRI_OFS = NUM_LINES / 2;

  logic [LINE_W-1:0] pri_line;
  logic [LINE_W-1:0] sec_line;
  logic [LINE_W-1:0] slot_base;

  assign slot_base = LINE_W'({devfn[4:3], 2'b00});
  assign pri_line  = LINE_W'(pin) + (devfn[0] ? LINE_W'(PRI_OFS) : '0);
  assign sec_line  = slot_base + LINE_W'(pin);
  assign line      = sec ? sec_line : pri_line;
  assign in_range  = (line < LINE_W'(NUM_LINES));

endmodule

// File: rtl/irqmap_gate.sv
module irqmap_gate #(
  parameter int unsigned NUM_LINES     = 32,
  parameter int unsigned LINES_PER_REG = 4,
  parameter int unsigned NUM_REGS      = 8,
  parameter int unsigned LINE_W        = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd_valid,
  input  logic [LINE_W-1:0]    upd_line,
  input  logic                 upd_in_range,
  input  logic                 upd_level,
  input  logic [NUM_REGS-1:0]  en,
  output logic [NUM_LINES-1:0] irq_out
);

  logic [NUM_LINES-1:0] lvl_q;
  logic [NUM_LINES-1:0] out_q;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int unsigned OWNER = n / LINES_PER_REG;
    logic hit;

    assign hit = upd_valid & upd_in_range & (upd_line == LINE_W'(n));

    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q[n] <= 1'b0;
        out_q[n] <= 1'b0;
      end else begin
        if (hit) lvl_q[n] <= upd_level;
        out_q[n] <= lvl_q[n] & en[OWNER];
      end
    end

    a_r5_gated_by_owner: assert property (@(posedge clk) disable iff (rst)
      out_q[n] |-> ($past(en[OWNER]) && $past(lvl_q[n])));
  end

  assign irq_out = out_q;

  a_r8_far_line_dropped: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_in_range) |=> $stable(lvl_q));

endmodule

// File: rtl/irqmap_top.sv
module irqmap_top #(
  parameter int unsigned NUM_REGS      = 8,
  parameter int unsigned LINES_PER_REG = 4,
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned WIN_BASE      = 'hC00,
  parameter int unsigned DEVFN_W       = 8,
  parameter int unsigned PIN_W         = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bridge_rst,
  input  logic                              cfg_wr,
  input  logic [ADDR_W-1:0]                 cfg_addr,
  input  logic [31:0]                       cfg_wdata,
  output logic [31:0]                       cfg_rdata,
  input  logic                              src_valid,
  output logic                              src_ready,
  input  logic                              src_sec,
  input  logic [DEVFN_W-1:0]                src_devfn,
  input  logic [PIN_W-1:0]                  src_pin,
  input  logic                              src_level,
  output logic [NUM_REGS*LINES_PER_REG-1:0] irq_out
);

  localparam int unsigned NUM_LINES = NUM_REGS * LINES_PER_REG;
  localparam int unsigned LN_W      = $clog2(NUM_LINES);
  localparam int unsigned LINE_W    = ((PIN_W > LN_W) ? PIN_W : LN_W) + 1;

  logic [NUM_REGS-1:0] en;
  logic [LINE_W-1:0]   line;
  logic                in_range;

  // R9: the update stream never back-pressures.
  assign src_ready = 1'b1;

  irqmap_regs #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bridge_rst (bridge_rst),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .en_o       (en)
  );

  irqmap_line_calc #(
    .DEVFN_W   (DEVFN_W),
    .PIN_W     (PIN_W),
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W)
  ) u_calc (
    .sec      (src_sec),
    .devfn    (src_devfn),
    .pin      (src_pin),
    .line     (line),
    .in_range (in_range)
  );

  irqmap_gate #(
    .NUM_LINES     (NUM_LINES),
    .LINES_PER_REG (LINES_PER_REG),
    .NUM_REGS      (NUM_REGS),
    .LINE_W        (LINE_W)
  ) u_gate (
    .clk          (clk),
    .rst          (rst),
    .upd_valid    (src_valid),
    .upd_line     (line),
    .upd_in_range (in_range),
    .upd_level    (src_level),
    .en           (en),
    .irq_out      (irq_out)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (irq_out == '0));

endmodule

// File: tb/irqmap_top_bench.sv
module irqmap_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bridge_rst = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic        src_sec = 1'b0;
  logic [7:0]  src_devfn = '0;
  logic [4:0]  src_pin = '0;
  logic        src_level = 1'b0;
  logic [31:0] irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  irqmap_top u_irqmap_top (
    .clk(clk), .rst(rst), .bridge_rst(bridge_rst),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .src_valid(src_valid), .src_ready(src_ready), .src_sec(src_sec),
    .src_devfn(src_devfn), .src_pin(src_pin), .src_level(src_level),
    .irq_out(irq_out)
  );

  // Reference model
  bit [7:0]  m_en;
  bit [31:0] m_lvl;
  bit [31:0] m_out;
  int        m_ln;

  function automatic int line_of(bit sec, bit [7:0] devfn, bit [4:0] pin);
    if (sec) return int'((devfn & 8'h18) >> 1) + int'(pin);
    return int'(pin) + (devfn[0] ? 16 : 0);
  endfunction

  function automatic bit reg_hit(bit [15:0] a);
    return (a >= 16'hC00) && (a <= 16'hC3F) && a[2];
  endfunction

  function automatic bit [31:0] exp_read(bit [15:0] a);
    int i;
    if (!reg_hit(a)) return 32'h0;
    i = int'(a[5:3]);
    return {m_en[i], 31'(32'h7C0 | (i << 2))};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = '0; m_lvl = '0; m_out = '0;
    end else begin
      for (int n = 0; n < 32; n++) m_out[n] = m_lvl[n] & m_en[n / 4];
      if (src_valid) begin
        m_ln = line_of(src_sec, src_devfn, src_pin);
        if (m_ln < 32) m_lvl[m_ln] = src_level;
      end
      if (bridge_rst) m_en = '0;
      else if (cfg_wr && reg_hit(cfg_addr)) m_en[cfg_addr[5:3]] = cfg_wdata[31];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model (R5, R9)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R5/R9 cycle compare", irq_out, m_out);
      chk("R9 ready", {31'b0, src_ready}, 32'h1);
    end
  end

  task automatic rd(input bit [15:0] a, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(tag, cfg_rdata, exp_read(a));
  endtask

  task automatic wr(input bit [15:0] a, input bit [31:0] d, input bit brst);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1; bridge_rst = brst;
    @(negedge clk);
    cfg_wr = 1'b0; bridge_rst = 1'b0;
  endtask

  task automatic send(input bit sec, input bit [7:0] devfn, input bit [4:0] pin, input bit lvl);
    @(negedge clk);
    src_sec = sec; src_devfn = devfn; src_pin = pin; src_level = lvl; src_valid = 1'b1;
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset values and quiet outputs
    chk("R1 outputs low", irq_out, 32'h0);
    for (int i = 0; i < 8; i++) rd(16'(16'hC04 + i * 8), "R1 reset value");
    chk("R1 reg0 literal", exp_read(16'hC04), 32'h0000_07C0);

    // R3 gaps and outside window
    rd(16'hC00, "R3 bit2 clear reads zero");
    rd(16'hC38, "R3 bit2 clear reads zero");
    rd(16'hC44, "R3 outside window reads zero");

    // R2 only bit 31 moves
    wr(16'hC04, 32'hFFFF_FFFF, 0);
    rd(16'hC04, "R2 enable only");
    wr(16'hC0C, 32'h7FFF_FFFF, 0);
    rd(16'hC0C, "R2 low bits ignored");
    // R3 ignored writes
    wr(16'hC10, 32'h8000_0000, 0);
    rd(16'hC14, "R3 bit2 clear write ignored");
    wr(16'hC4C, 32'h8000_0000, 0);
    rd(16'hC0C, "R3 out-of-window write ignored");

    for (int i = 0; i < 8; i++) wr(16'(16'hC04 + i * 8), 32'h8000_0000, 0);

    // R6 / R9 primary bus
    send(0, 8'h01, 5'd2, 1);
    chk("R9 not yet visible", {31'b0, irq_out[18]}, 32'h0);
    @(negedge clk);
    chk("R6 primary devfn bit0 -> line 18", {31'b0, irq_out[18]}, 32'h1);
    send(0, 8'h08, 5'd3, 1);
    @(negedge clk);
    chk("R6 primary -> line 3", {31'b0, irq_out[3]}, 32'h1);
    send(0, 8'h01, 5'd15, 1);
    @(negedge clk);
    chk("R6 boundary line 31", {31'b0, irq_out[31]}, 32'h1);

    // R7 secondary bridge
    send(1, 8'h18, 5'd1, 1);
    @(negedge clk);
    chk("R7 secondary -> line 13", {31'b0, irq_out[13]}, 32'h1);
    send(1, 8'h11, 5'd0, 1);
    @(negedge clk);
    chk("R7 secondary bit0 ignored -> line 8", {31'b0, irq_out[8]}, 32'h1);

    // R8 out of range
    @(negedge clk); snap = irq_out;
    send(0, 8'h01, 5'd20, 1);
    @(negedge clk);
    chk("R8 line 36 dropped", irq_out, snap);
    send(1, 8'h18, 5'd25, 1);
    @(negedge clk);
    chk("R8 line 37 dropped", irq_out, snap);

    // R5 gating and remembered level
    wr(16'hC24, 32'h0, 0);
    @(negedge clk);
    chk("R5 disabled line low", {31'b0, irq_out[18]}, 32'h0);
    send(0, 8'h01, 5'd2, 0);
    send(0, 8'h01, 5'd17, 1);   // line 33, dropped
    wr(16'hC24, 32'h8000_0000, 0);
    @(negedge clk);
    chk("R5 re-enabled low level stays low", {31'b0, irq_out[18]}, 32'h0);
    send(0, 8'h01, 5'd3, 1);    // line 19
    wr(16'hC24, 32'h0, 0);
    wr(16'hC24, 32'h8000_0000, 0);
    @(negedge clk);
    chk("R5 level remembered while gated", {31'b0, irq_out[19]}, 32'h1);
    send(1, 8'h18, 5'd1, 0);
    @(negedge clk);
    chk("R5 follows falling level", {31'b0, irq_out[13]}, 32'h0);

    // R4 / R10 bridge reset with same-cycle write
    wr(16'hC04, 32'h8000_0000, 1);
    @(negedge clk);
    chk("R4 outputs gated off", irq_out, 32'h0);
    for (int i = 0; i < 8; i++) rd(16'(16'hC04 + i * 8), "R4 routing kept, enable clear");
    chk("R10 write lost to bridge reset", {31'b0, exp_read(16'hC04)[31]}, 32'h0);
    wr(16'hC04, 32'h8000_0000, 0);
    @(negedge clk);
    chk("R5 stored level returns", {31'b0, irq_out[3]}, 32'h1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule